// File: doc/BRIEF.md
# Overlapped-Block Soft-Decision Viterbi Decoder

This block decodes a rate-1/2, constraint-length-7 convolutional code (generators 171 and 133 octal) from a stream of signed 8-bit soft symbol pairs. The stream is cut into blocks that overlap their neighbours. Each block first runs a warm-up stretch of `M` trellis steps, then a kept stretch of `D` steps, then a settling stretch of `L` steps. For every step it runs add-compare-select for all 64 states at once and stores one survivor decision per state. When a block is complete, a traceback starts at its last step and walks back through the settling stretch. It writes only the bits of the kept stretch into a small reorder buffer. It then plays those bits out oldest first.

Two neighbouring blocks share `M+L` input steps, so every trellis step is kept by exactly one block. The decoder holds the last `M+L` symbol pairs and replays them to seed the next block, whose metrics start at zero. The first block of a stream has no warm-up stretch and starts from state 0. The sender ends each stream with six zero tail bits and marks the final symbol pair. The final block is then traced back from state 0, and the tail bits are dropped. Path metrics use modulo arithmetic and are compared through the sign of their wrapped difference, so they are never renormalised.

Top module: `ovl_viterbi`

## Requirements
- R1: From reset, or after the end of a stream, decoding starts in encoder state 0. A clean stream gives back exactly the source bits, in source order. The tail is not emitted.
- R2: A stream of n symbol pairs, of which the last 6 carry the zero tail, yields exactly n-6 output bits. Each output bit is presented for one cycle with `out_valid` high.
- R3: The soft symbols are two's-complement. A positive value favours code bit 1 and a negative value favours code bit 0. `in_sym0` carries the output of generator 171 and `in_sym1` the output of generator 133. The full range, including -128, decodes without overflow, and so do very small magnitudes.
- R4: The encoder state holds the six previous inputs. The newest input taps the most significant generator coefficient. An inverted symbol on isolated trellis steps, at least 20 steps apart, is corrected.
- R5: Streams that end exactly at a block end, one step before it, one step after it, or at the end of the second block all decode correctly. The first block covers `D+L` steps. Each later block covers `M+D+L` steps and shares `M+L` of them with the block before it.
- R6: A symbol pair is taken only in a cycle with both `in_valid` and `in_ready` high. `in_ready` never drops while a pair is offered and not yet taken. Idle cycles on `in_valid` lose no data.
- R7: After reset, `in_ready` is 1 and `out_valid` is 0. `out_valid` and `in_ready` are never high in the same cycle.
- R8: A new stream may follow the final pair of the previous one with no reset in between. It decodes as if it came from reset.
- R9: Path metrics wrap modulo 2^PMW without renormalisation. The spread between any state's metric and that of state 0 stays below 2^(PMW-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A soft symbol pair is offered |
| in_ready | output | 1 | The decoder takes the offered pair |
| in_sym0 | input | SW | Soft symbol for generator 171 |
| in_sym1 | input | SW | Soft symbol for generator 133 |
| in_last | input | 1 | Marks the final pair of a stream (the last tail step) |
| out_valid | output | 1 | A decoded bit is presented |
| out_bit | output | 1 | Decoded bit, in stream order |

## Verification
Two events can fall in the same step: the arrival of the stream's final pair and the natural end of a block. When both happen, the final-block rule (trace back from state 0 and drop the tail) must override the normal rule (trace back from the best state and keep only `D` bits). Streams are sized so that the marked pair lands exactly on the last step of the first block, one step before and after it, and on the last step of the second block. Each of these is judged by the exact output bit count and a bit-for-bit comparison with the source.

// File: rtl/ovl_viterbi.sv
module ovl_viterbi #(
  parameter int D   = 512,
  parameter int M   = 35,
  parameter int L   = 35,
  parameter int SW  = 8,
  parameter int PMW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_sym0,
  input  logic [SW-1:0] in_sym1,
  input  logic          in_last,
  output logic          out_valid,
  output logic          out_bit
);
  localparam int K     = 7;
  localparam int NS    = 1 << (K - 1);
  localparam int TAIL  = K - 1;
  localparam int NSTEP = M + D + L;
  localparam int RING  = M + L;
  localparam int OB    = D + L;
  localparam int SI    = $clog2(NSTEP);
  localparam int RW    = $clog2(RING);
  localparam int OI    = $clog2(OB);
  localparam int BW    = SW + 2;
  localparam logic [PMW-1:0] PEN = {4'hF, {(PMW-4){1'b0}}};

  typedef enum logic [2:0] {S_IN, S_REP, S_PICK, S_TB, S_OUT} st_t;

  st_t st;
  logic [NS-1:0][PMW-1:0] pm, pm_nx;
  logic [NS-1:0] dec;
  logic [NS-1:0] surv [NSTEP];
  logic [SW-1:0] ring0 [RING];
  logic [SW-1:0] ring1 [RING];
  logic [OB-1:0] obuf;
  logic [RW-1:0] wp, rp;
  logic [SI-1:0] step, tb_j, pre, rel;
  logic [OI-1:0] oend, oidx;
  logic          first, fin, acs;
  logic [5:0]    tb_s, best;
  logic [PMW-1:0] bd;
  logic [SW-1:0] y0, y1;
  logic signed [BW-1:0] e0, e1;
  logic signed [BW-1:0] bm [4];

  assign in_ready  = (st == S_IN);
  assign out_valid = (st == S_OUT);
  assign out_bit   = obuf[oidx];
  assign pre       = first ? '0 : SI'(M);
  assign rel       = tb_j - pre;
  assign acs       = (st == S_REP) || (st == S_IN && in_valid);
  assign y0        = (st == S_REP) ? ring0[rp] : in_sym0;
  assign y1        = (st == S_REP) ? ring1[rp] : in_sym1;
  assign e0        = {{2{y0[SW-1]}}, y0};
  assign e1        = {{2{y1[SW-1]}}, y1};

  for (genvar c = 0; c < 4; c++) begin : g_bm
    assign bm[c] = (((c / 2) == 1) ? e0 : -e0) + (((c % 2) == 1) ? e1 : -e1);
  end

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam logic [6:0] V0 = 7'(2 * n);
    localparam logic [6:0] V1 = 7'(2 * n + 1);
    localparam int C0 = {^(V0 & 7'o171), ^(V0 & 7'o133)};
    localparam int C1 = {^(V1 & 7'o171), ^(V1 & 7'o133)};
    logic [PMW-1:0] c0, c1, df;
    assign c0 = pm[V0[5:0]] + {{(PMW-BW){bm[C0][BW-1]}}, bm[C0]};
    assign c1 = pm[V1[5:0]] + {{(PMW-BW){bm[C1][BW-1]}}, bm[C1]};
    assign df = c1 - c0;
    assign dec[n]   = !df[PMW-1] && (df != '0);
    assign pm_nx[n] = dec[n] ? c1 : c0;
  end

  always_comb begin
    best = '0;
    bd   = '0;
    for (int i = 1; i < NS; i++) begin
      bd = pm[i] - pm[best];
      if (!bd[PMW-1] && bd != '0) best = 6'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IN;
      first <= 1'b1;
      fin   <= 1'b0;
      step  <= '0;
      wp    <= '0;
      rp    <= '0;
      tb_j  <= '0;
      tb_s  <= '0;
      oend  <= '0;
      oidx  <= '0;
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : PEN;
    end else begin
      if (acs) pm <= pm_nx;
      case (st)
        S_IN: if (in_valid) begin
          wp <= (wp == RW'(RING - 1)) ? '0 : wp + 1'b1;
          if (in_last || step == pre + SI'(D + L - 1)) begin
            fin  <= in_last;
            tb_j <= step;
            oend <= in_last ? OI'(step - SI'(TAIL) - pre) : OI'(D - 1);
            st   <= S_PICK;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_REP: begin
          rp   <= (rp == RW'(RING - 1)) ? '0 : rp + 1'b1;
          step <= step + 1'b1;
          if (step == SI'(RING - 1)) st <= S_IN;
        end
        S_PICK: begin
          tb_s <= fin ? '0 : best;
          st   <= S_TB;
        end
        S_TB: begin
          tb_s <= {tb_s[4:0], surv[tb_j][tb_s]};
          if (tb_j == pre) begin
            oidx <= '0;
            st   <= S_OUT;
          end else begin
            tb_j <= tb_j - 1'b1;
          end
        end
        S_OUT: begin
          if (oidx == oend) begin
            step <= '0;
            if (fin) begin
              first <= 1'b1;
              fin   <= 1'b0;
              st    <= S_IN;
              for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : PEN;
            end else begin
              first <= 1'b0;
              rp    <= wp;
              st    <= S_REP;
              pm    <= '0;
            end
          end else begin
            oidx <= oidx + 1'b1;
          end
        end
        default: st <= S_IN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acs) surv[step] <= dec;
    if (st == S_IN && in_valid) begin
      ring0[wp] <= in_sym0;
      ring1[wp] <= in_sym1;
    end
    if (st == S_TB && rel <= SI'(oend)) obuf[OI'(rel)] <= tb_s[5];
  end
endmodule

// File: rtl/ovl_viterbi_chk.sv
module ovl_viterbi_chk #(
  parameter int NS  = 64,
  parameter int PMW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_bit,
  input logic [NS-1:0][PMW-1:0] pm
);
  localparam logic [PMW-1:0] LIM = {2'b01, {(PMW-2){1'b0}}};
  logic           spread_ok;
  logic [PMW-1:0] d;

  always_comb begin
    spread_ok = 1'b1;
    d = '0;
    for (int i = 1; i < NS; i++) begin
      d = pm[i] - pm[0];
      if (d[PMW-1]) d = -d;
      if (d >= LIM) spread_ok = 1'b0;
    end
  end

  a_r7_out_excludes_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r6_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
  a_r2_out_known: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_bit));
  a_r9_metric_spread: assert property (@(posedge clk) disable iff (!rst_n)
    spread_ok);
  a_r1_quiet_while_taking: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);
endmodule

bind ovl_viterbi ovl_viterbi_chk #(.NS(64), .PMW(PMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_bit(out_bit), .pm(pm)
);

// File: tb/ovl_viterbi_bench.sv
module ovl_viterbi_bench;
  localparam int D = 200;
  localparam int MAXS = 4200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_sym0 = '0, in_sym1 = '0;
  logic in_ready, out_valid, out_bit;

  int nchk = 0, nfail = 0;
  logic src [MAXS];
  logic [7:0] s0 [MAXS];
  logic [7:0] s1 [MAXS];

  always #4 clk = ~clk;

  ovl_viterbi #(.D(D)) u_ovl_viterbi (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym0(in_sym0), .in_sym1(in_sym1), .in_last(in_last),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  // columns: data bits (= expected output count), seed, error spacing, gaps, amplitude, requirement
  localparam int NV = 9;
  localparam int VT [NV][6] = '{
    '{  10,  5,  0, 0, 100, 1},  // R1 short stream
    '{ 229,  7,  0, 0, 100, 5},  // R5 final pair on last step of first block
    '{ 228,  9,  0, 1, 100, 5},  // R5 one step early, with idle cycles (R6)
    '{ 230, 11,  0, 0, 100, 5},  // R5 one step into second block
    '{ 429, 13,  0, 0, 100, 5},  // R5 final pair on last step of second block
    '{ 600, 17, 23, 0, 100, 4},  // R4 isolated inverted symbols
    '{ 500, 19,  0, 0, 128, 3},  // R3 full-scale symbols including -128
    '{ 400, 23,  0, 1,   4, 3},  // R3 weak symbols, idle cycles (R6)
    '{1500, 29, 31, 1, 100, 9}   // R9 long stream, metrics wrap
  };

  function automatic string rq(int r);
    case (r)
      1: return "R1"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 9: return "R9"; default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sym(input logic b, input int amp);
    return b ? 8'((amp > 127) ? 127 : amp) : 8'(-amp);
  endfunction

  task automatic build(input int nb, input int seed, input int ep, input int amp);
    logic [31:0] lf = 32'(seed);
    logic [5:0] sr = '0;
    for (int k = 0; k < nb + 6; k++) begin
      logic u, c0, c1, flip;
      logic [6:0] v;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      u = (k < nb) ? lf[0] : 1'b0;
      src[k] = u;
      v = {u, sr};
      c0 = ^(v & 7'o171);
      c1 = ^(v & 7'o133);
      sr = {u, sr[5:1]};
      flip = (ep > 0) && ((k % ep) == ep / 2);
      s0[k] = sym(c0 ^ flip, amp);
      s1[k] = sym(c1, amp);
    end
  endtask

  task automatic run(input int nb, input int seed, input int ep, input int gap, input int amp, input string req);
    int got = 0, bad = 0, idle = 0, viol = 0, n = nb + 6;
    bit done = 0;
    build(nb, seed, ep, amp);
    fork
      begin
        int k = 0, cyc = 0;
        while (k < n) begin
          @(negedge clk);
          cyc++;
          in_valid = (gap == 0) || (cyc % 3 != 0);
          in_sym0 = s0[k];
          in_sym1 = s1[k];
          in_last = (k == n - 1);
          if (in_valid && in_ready) k++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        done = 1;
      end
      begin
        while (!(done && idle >= 600)) begin
          @(negedge clk);
          if (out_valid) begin
            if (got < nb && out_bit !== src[got]) bad++;
            if (in_ready) viol++;
            got++;
            idle = 0;
          end else idle++;
        end
      end
    join
    chk(got == nb, "R2", "output bit count", got, nb);
    chk(bad == 0, req, "mismatching decoded bits", bad, 0);
    chk(viol == 0, "R7", "out_valid with in_ready", viol, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R7", "in_ready in reset", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R7", "in_ready after reset", int'(in_ready), 1);
    // streams follow one another with no reset in between (R8)
    for (int i = 0; i < NV; i++)
      run(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], rq(VT[i][5]));
    run(300, 41, 0, 0, 100, "R8");
    // reset in the middle of a stream, then a fresh stream (R7, R1)
    build(300, 43, 0, 100);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sym0 = s0[k]; in_sym1 = s1[k]; in_last = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7", "out_valid after mid-stream reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R7", "in_ready after mid-stream reset", int'(in_ready), 1);
    rst_n = 1'b1;
    run(80, 47, 0, 1, 100, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule